// File: doc/BRIEF.md
# Fence-Range Tiled Address Translator

This block sits in the address path of a linear graphics aperture. It holds a small file of fence registers, each describing one page-aligned window of the aperture together with a row pitch and a tiling mode. Each incoming linear byte address is checked against every enabled fence. On a match it is rewritten into the tiled physical layout: 512-byte by 8-row tiles for X mode, or 128-byte by 32-row tiles stored as 16-byte columns for Y mode. An address outside every enabled window leaves unchanged.

Software programs each fence as two 32-bit halves through a simple write port and can read both halves back. A fence only takes part in matching while its enable bit is set. Software clears the low half first, then writes the high half, then writes the low half with the enable bit set. Because of this order, translation never uses a partially written descriptor. Requests and responses use valid/ready handshakes, and the latency is a fixed two cycles.

Top module: `fence_xlate`

## Requirements
- R1: While reset is asserted and immediately after it, every fence half reads back as zero, `rsp_valid_o` is low and `req_ready_o` is high.
- R2: A write with `cfg_hi_i`=0 stores the low half and one with `cfg_hi_i`=1 stores the high half of fence `cfg_idx_i`. The stored word reads back unchanged on `cfg_rdata_o`. Low-half layout: bits 31:12 hold the first page, bits 11:2 hold the pitch code (stride/128 - 1), bit 1 selects Y tiling and bit 0 enables the fence. In the high half, bits 31:12 hold the last page.
- R3: An address that no enabled fence covers is returned unchanged, with `rsp_hit_o`=0 and `rsp_fence_o`=0.
- R4: A fence whose enable bit is clear is ignored, including one that is half written (low half zero, high half already written). A matching address passes through unchanged.
- R5: A fence covers byte addresses whose page number lies between its first and last page, both ends inclusive. The byte just past the last page is a miss.
- R6: In X mode, with offset = addr - first_page*4096, row = offset/stride and col = offset%stride, the result is first_page*4096 + (row/8)*stride*8 + (col/512)*4096 + (row%8)*512 + col%512.
- R7: In Y mode, the result is first_page*4096 + (row/32)*stride*32 + (col/128)*4096 + ((col%128)/16)*512 + (row%32)*16 + col%16.
- R8: When several enabled fences cover an address, the one with the lowest index is used.
- R9: A request accepted while `rsp_ready_i` is high in the following cycle appears on the response two clock edges after acceptance.
- R10: While `rsp_valid_o` is high and `rsp_ready_i` is low, the response holds steady. Once both stages are full, `req_ready_o` drops. Responses leave in request order with none lost.
- R11: On a hit, `rsp_fence_o` carries the index of the fence that was used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Fence half write strobe |
| cfg_idx_i | input | 4 | Fence index for writes |
| cfg_hi_i | input | 1 | Write targets the high half |
| cfg_wdata_i | input | 32 | Write data |
| cfg_ridx_i | input | 4 | Fence index for read-back |
| cfg_rhi_i | input | 1 | Read-back selects the high half |
| cfg_rdata_o | output | 32 | Read-back data (combinational) |
| req_valid_i | input | 1 | Request address valid |
| req_ready_o | output | 1 | Request accepted this edge when high |
| req_addr_i | input | 32 | Linear byte address |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response consumer ready |
| rsp_addr_o | output | 32 | Translated or passed-through address |
| rsp_hit_o | output | 1 | Address was translated by a fence |
| rsp_fence_o | output | 4 | Index of the fence used, zero on a miss |

## Verification
The read-back property assumes the stimulus does not write the same register again in the cycle it is read. It also assumes no write is in progress during reset. The bench drives every strobe from the falling edge and keeps write and read selects apart. The latency property assumes the request inputs are idle at reset, which the bench guarantees. Every stride the bench programs is a whole number of tile widths and every window is a whole number of tile rows, so the expected addresses follow the tiling formulas exactly.

// File: rtl/fence_xlate_pkg.sv
package fence_xlate_pkg;
  localparam int PAGE_W    = 20;
  localparam int PCODE_W   = 10;
  localparam int PCODE_LSB = 2;
  localparam int YSEL_BIT  = 1;
  localparam int VLD_BIT   = 0;

  typedef struct packed {
    logic               vld;
    logic               ytile;
    logic [PCODE_W-1:0] pcode;
    logic [PAGE_W-1:0]  first_pg;
    logic [PAGE_W-1:0]  last_pg;
  } fence_t;
endpackage

// File: rtl/fence_regs.sv
module fence_regs
  import fence_xlate_pkg::*;
#(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] idx_i,
  input  logic          hi_i,
  input  logic [31:0]   wdata_i,
  input  logic [IW-1:0] ridx_i,
  input  logic          rhi_i,
  output logic [31:0]   rdata_o,
  output fence_t        fence_o [N]
);
  logic [31:0] lo_q [N];
  logic [31:0] hi_q [N];

  for (genvar g = 0; g < N; g++) begin : g_fence
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q[g] <= '0;
        hi_q[g] <= '0;
      end else if (we_i && idx_i == IW'(g)) begin
        if (hi_i) hi_q[g] <= wdata_i;
        else      lo_q[g] <= wdata_i;
      end
    end

    assign fence_o[g].vld      = lo_q[g][VLD_BIT];
    assign fence_o[g].ytile    = lo_q[g][YSEL_BIT];
    assign fence_o[g].pcode    = lo_q[g][PCODE_LSB +: PCODE_W];
    assign fence_o[g].first_pg = lo_q[g][31 -: PAGE_W];
    assign fence_o[g].last_pg  = hi_q[g][31 -: PAGE_W];
  end

  assign rdata_o = rhi_i ? hi_q[ridx_i] : lo_q[ridx_i];
endmodule

// File: rtl/fence_match.sv
module fence_match
  import fence_xlate_pkg::*;
#(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [PAGE_W-1:0] page_i,
  input  fence_t            fence_i [N],
  output logic              hit_o,
  output logic [IW-1:0]     idx_o
);
  logic [N-1:0] in_win;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign in_win[g] = fence_i[g].vld &&
                       page_i >= fence_i[g].first_pg &&
                       page_i <= fence_i[g].last_pg;
  end

  // scan downwards so the lowest matching index is assigned last
  always_comb begin
    hit_o = |in_win;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (in_win[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/fence_tiler.sv
module fence_tiler
  import fence_xlate_pkg::*;
(
  input  logic [31:0]        addr_i,
  input  logic [PAGE_W-1:0]  base_pg_i,
  input  logic [PCODE_W-1:0] pcode_i,
  input  logic               ytile_i,
  output logic [31:0]        phys_o
);
  logic [31:0] base, off, pdiv, stride, row, col_x;
  logic [31:0] tile_row, tile_col, band, inner;

  always_comb begin
    base   = {base_pg_i, 12'h000};
    off    = addr_i - base;
    pdiv   = 32'(pcode_i) + 32'd1;
    stride = pdiv << 7;
    // stride = pdiv*128, so only the quotient by pdiv is a true divide
    row    = {7'b0, off[31:7]} / pdiv;
    col_x  = off - row * stride;
    if (ytile_i) begin
      tile_row = row >> 5;
      tile_col = col_x >> 7;
      band     = (tile_row * stride) << 5;
      inner    = {20'b0, col_x[6:4], row[4:0], col_x[3:0]};
    end else begin
      tile_row = row >> 3;
      tile_col = col_x >> 9;
      band     = (tile_row * stride) << 3;
      inner    = {20'b0, row[2:0], col_x[8:0]};
    end
    phys_o = base + band + (tile_col << 12) + inner;
  end
endmodule

// File: rtl/fence_xlate.sv
module fence_xlate
  import fence_xlate_pkg::*;
#(
  parameter int NUM_FENCES = 16,
  localparam int IdxW = $clog2(NUM_FENCES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [IdxW-1:0] cfg_idx_i,
  input  logic            cfg_hi_i,
  input  logic [31:0]     cfg_wdata_i,
  input  logic [IdxW-1:0] cfg_ridx_i,
  input  logic            cfg_rhi_i,
  output logic [31:0]     cfg_rdata_o,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [31:0]     req_addr_i,
  output logic            rsp_valid_o,
  input  logic            rsp_ready_i,
  output logic [31:0]     rsp_addr_o,
  output logic            rsp_hit_o,
  output logic [IdxW-1:0] rsp_fence_o
);
  fence_t fences [NUM_FENCES];
  fence_t sel;
  logic            m_hit;
  logic [IdxW-1:0] m_idx;

  logic               s1_vld, s1_hit, s1_y;
  logic [31:0]        s1_addr;
  logic [IdxW-1:0]    s1_idx;
  logic [PAGE_W-1:0]  s1_base;
  logic [PCODE_W-1:0] s1_pcode;
  logic [31:0]        t_phys;
  logic               s1_en, s2_en;

  fence_regs #(.N(NUM_FENCES)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .idx_i   (cfg_idx_i),
    .hi_i    (cfg_hi_i),
    .wdata_i (cfg_wdata_i),
    .ridx_i  (cfg_ridx_i),
    .rhi_i   (cfg_rhi_i),
    .rdata_o (cfg_rdata_o),
    .fence_o (fences)
  );

  fence_match #(.N(NUM_FENCES)) u_match (
    .page_i  (req_addr_i[31:12]),
    .fence_i (fences),
    .hit_o   (m_hit),
    .idx_o   (m_idx)
  );

  assign sel = fences[m_idx];

  assign s2_en       = !rsp_valid_o || rsp_ready_i;
  assign s1_en       = !s1_vld || s2_en;
  assign req_ready_o = s1_en;

  // stage 1: match result and a snapshot of the chosen fence
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld   <= 1'b0;
      s1_hit   <= 1'b0;
      s1_y     <= 1'b0;
      s1_addr  <= '0;
      s1_idx   <= '0;
      s1_base  <= '0;
      s1_pcode <= '0;
    end else if (s1_en) begin
      s1_vld   <= req_valid_i;
      s1_hit   <= m_hit;
      s1_y     <= sel.ytile;
      s1_addr  <= req_addr_i;
      s1_idx   <= m_idx;
      s1_base  <= sel.first_pg;
      s1_pcode <= sel.pcode;
    end
  end

  fence_tiler u_tiler (
    .addr_i    (s1_addr),
    .base_pg_i (s1_base),
    .pcode_i   (s1_pcode),
    .ytile_i   (s1_y),
    .phys_o    (t_phys)
  );

  // stage 2: response register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_addr_o  <= '0;
      rsp_hit_o   <= 1'b0;
      rsp_fence_o <= '0;
    end else if (s2_en) begin
      rsp_valid_o <= s1_vld;
      rsp_addr_o  <= s1_hit ? t_phys : s1_addr;
      rsp_hit_o   <= s1_hit;
      rsp_fence_o <= s1_hit ? s1_idx : '0;
    end
  end
endmodule

// File: rtl/fence_xlate_chk.sv
module fence_xlate_chk #(
  parameter int NUM_FENCES = 16,
  localparam int IdxW = $clog2(NUM_FENCES)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cfg_we_i,
  input logic [IdxW-1:0] cfg_idx_i,
  input logic            cfg_hi_i,
  input logic [31:0]     cfg_wdata_i,
  input logic [IdxW-1:0] cfg_ridx_i,
  input logic            cfg_rhi_i,
  input logic [31:0]     cfg_rdata_o,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic            rsp_valid_o,
  input logic            rsp_ready_i,
  input logic [31:0]     rsp_addr_o,
  input logic            rsp_hit_o,
  input logic [IdxW-1:0] rsp_fence_o
);
  AST_RESET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !rsp_valid_o); // R1

  AST_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cfg_we_i) && !cfg_we_i && cfg_ridx_i == $past(cfg_idx_i) &&
     cfg_rhi_i == $past(cfg_hi_i)) |-> cfg_rdata_o == $past(cfg_wdata_i)); // R2

  AST_FIXED_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rsp_ready_i) && $past(req_valid_i && req_ready_o, 2)) |-> rsp_valid_o); // R9

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_addr_o))); // R10

  AST_STALL_INDEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> ($stable(rsp_hit_o) && $stable(rsp_fence_o))); // R11
endmodule

bind fence_xlate fence_xlate_chk #(.NUM_FENCES(NUM_FENCES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_idx_i   (cfg_idx_i),
  .cfg_hi_i    (cfg_hi_i),
  .cfg_wdata_i (cfg_wdata_i),
  .cfg_ridx_i  (cfg_ridx_i),
  .cfg_rhi_i   (cfg_rhi_i),
  .cfg_rdata_o (cfg_rdata_o),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ready_i (rsp_ready_i),
  .rsp_addr_o  (rsp_addr_o),
  .rsp_hit_o   (rsp_hit_o),
  .rsp_fence_o (rsp_fence_o)
);

// File: tb/fence_xlate_test.sv
`timescale 1ns/1ps
module fence_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_hi = 1'b0, cfg_rhi = 1'b0;
  logic [3:0]  cfg_idx = '0, cfg_ridx = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_ready = 1'b1, rsp_hit;
  logic [31:0] rsp_addr;
  logic [3:0]  rsp_fence;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fence_xlate uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_hi_i(cfg_hi), .cfg_wdata_i(cfg_wdata),
    .cfg_ridx_i(cfg_ridx), .cfg_rhi_i(cfg_rhi), .cfg_rdata_o(cfg_rdata),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_addr_o(rsp_addr),
    .rsp_hit_o(rsp_hit), .rsp_fence_o(rsp_fence)
  );

  // vectors: address, expected address, {hit, fence}, requirement number
  localparam logic [31:0] V_ADDR [12] = '{
    32'h0000_1234, 32'h0010_0000, 32'h0010_0A05, 32'h0010_26BC,
    32'h0010_FFFF, 32'h0011_0000, 32'h0020_0625, 32'h0020_512C,
    32'h0040_0300, 32'h0040_8300, 32'h0050_0A05, 32'h001F_FFFF};
  localparam logic [31:0] V_EXP [12] = '{
    32'h0000_1234, 32'h0010_0000, 32'h0010_1405, 32'h0010_32BC,
    32'h0010_FFFF, 32'h0011_0000, 32'h0020_0435, 32'h0020_648C,
    32'h0040_0300, 32'h0040_8060, 32'h0050_0A05, 32'h001F_FFFF};
  localparam logic [4:0] V_META [12] = '{
    5'h00, 5'h10, 5'h10, 5'h10, 5'h10, 5'h00,
    5'h11, 5'h11, 5'h12, 5'h15, 5'h00, 5'h00};
  localparam int V_REQ [12] = '{3, 5, 6, 6, 5, 5, 7, 7, 8, 8, 4, 3};

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h exp %h", req, what, got, exp);
    end
  endtask

  task automatic cfg_wr(input int idx, input bit hi, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_hi = hi; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // R2: clear low half, write high half, then low half with enable last
  task automatic prog(input int idx, input logic [19:0] first_pg, input logic [19:0] last_pg,
                      input logic [9:0] pcode, input bit ytile, input bit vld);
    cfg_wr(idx, 1'b0, 32'h0);
    cfg_wr(idx, 1'b1, {last_pg, 12'h000});
    cfg_wr(idx, 1'b0, {first_pg, pcode, ytile, vld});
  endtask

  task automatic rd_chk(input int idx, input bit hi, input logic [31:0] exp, input string req);
    @(negedge clk);
    cfg_ridx = 4'(idx); cfg_rhi = hi;
    #1;
    chk(cfg_rdata == exp, req, "readback", cfg_rdata, exp);
  endtask

  task automatic xlate(input logic [31:0] a, input logic [31:0] ea, input bit eh,
                       input logic [3:0] ei, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    #1;
    chk(req_ready == 1'b1, "R10", "ready idle", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b0, "R9", "valid after one edge", 32'(rsp_valid), 32'd0);
    @(negedge clk);
    chk(rsp_valid == 1'b1, "R9", "valid after two edges", 32'(rsp_valid), 32'd1);
    chk(rsp_addr == ea, req, "address", rsp_addr, ea);
    chk(rsp_hit == eh, req, "hit", 32'(rsp_hit), 32'(eh));
    chk(rsp_fence == ei, eh ? "R11" : "R3", "fence index", 32'(rsp_fence), 32'(ei));
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0, "R1", "valid in reset", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1", "valid after reset", 32'(rsp_valid), 32'd0);
    chk(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 32'd1);
    rd_chk(0, 1'b0, 32'h0, "R1");
    rd_chk(15, 1'b1, 32'h0, "R1");

    prog(0, 20'h00100, 20'h0010F, 10'd7, 1'b0, 1'b1);
    prog(1, 20'h00200, 20'h0020F, 10'd3, 1'b1, 1'b1);
    prog(2, 20'h00400, 20'h00407, 10'd3, 1'b0, 1'b1);
    prog(3, 20'h00500, 20'h0050F, 10'd3, 1'b0, 1'b0);
    prog(5, 20'h00400, 20'h0040F, 10'd0, 1'b1, 1'b1);

    // R2: readback of both halves
    rd_chk(0, 1'b0, 32'h0010_001D, "R2");
    rd_chk(0, 1'b1, 32'h0010_F000, "R2");
    rd_chk(1, 1'b0, 32'h0020_000F, "R2");
    rd_chk(3, 1'b0, 32'h0050_000C, "R2");

    // vector walk: R3 R4 R5 R6 R7 R8
    for (int i = 0; i < 12; i++) begin
      xlate(V_ADDR[i], V_EXP[i], V_META[i][4], V_META[i][3:0], $sformatf("R%0d", V_REQ[i]));
    end

    // R4: half-written fence 6 is ignored until its enable lands
    cfg_wr(6, 1'b0, 32'h0);
    cfg_wr(6, 1'b1, 32'h0060_F000);
    xlate(32'h0000_1234, 32'h0000_1234, 1'b0, 4'd0, "R4");
    cfg_wr(6, 1'b0, {20'h00600, 10'd7, 1'b0, 1'b1});
    xlate(32'h0060_0A05, 32'h0060_1405, 1'b1, 4'd6, "R6");

    // R10: backpressure, hold and order
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_addr = 32'h0010_0A05;
    @(negedge clk);
    req_addr = 32'h0000_1234;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R10", "stalled valid", 32'(rsp_valid), 32'd1);
    chk(rsp_addr == 32'h0010_1405, "R10", "first out", rsp_addr, 32'h0010_1405);
    chk(req_ready == 1'b0, "R10", "ready when full", 32'(req_ready), 32'd0);
    repeat (3) @(negedge clk);
    chk(rsp_addr == 32'h0010_1405, "R10", "held out", rsp_addr, 32'h0010_1405);
    chk(rsp_hit == 1'b1, "R10", "held hit", 32'(rsp_hit), 32'd1);
    chk(req_ready == 1'b0, "R10", "still full", 32'(req_ready), 32'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b1, "R10", "second valid", 32'(rsp_valid), 32'd1);
    chk(rsp_addr == 32'h0000_1234, "R10", "second out", rsp_addr, 32'h0000_1234);
    chk(rsp_hit == 1'b0, "R10", "second miss", 32'(rsp_hit), 32'd0);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10", "drained", 32'(rsp_valid), 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule